// File: doc/BRIEF.md
# Multi-Line Tagged Receive Silo

This block collects received characters from up to sixteen asynchronous serial lines into one shared first-in first-out store. Each line has its own push port and a one-deep holding stage. A fixed-priority arbiter moves at most one held character per cycle into a 64-entry silo. The entry is tagged with the source line number and with the parity, framing and overrun status of that character.

The host takes characters out by reading a 16-bit next-character word. The top bit of the word tells whether the word carries a character, and each read strobe removes exactly one entry. The host keeps reading until the top bit comes back clear. A programmable alarm level lets characters pile up so that the host can fetch them in batches. An external flush pulse forces the interrupt for whatever is waiting, so a slow trickle of characters is never stranded below the alarm level.

Each push port follows valid/ready rules. A character transfers on a clock edge where `push_valid` and `push_ready` are both high. `push_ready` drops only while that line's holding stage is occupied and has lost arbitration. While `push_ready` is low, the sender must hold its character and its flags steady. Silo fullness never stalls a push port: a character that wins arbitration while the silo is full is discarded.

Top module: `mux_rx_silo`

## Requirements
- R1: After reset, `rd_word` bit 15 is 0, `irq` is 0, every `push_ready` bit is 1, and the alarm level is 0.
- R2: A non-empty silo presents its oldest entry on `rd_word` with bit 15 = 1, bits 11:8 = the source line number and bits 7:0 = the character. An empty silo presents `rd_word` = 16'h0000.
- R3: Bit 12 of the word is the parity-error flag and bit 13 is the framing-error flag, both taken from the line's push inputs with that character.
- R4: Each cycle with `rd_en` high removes exactly one entry if the silo is non-empty. A read of an empty silo changes nothing. Entries leave in arrival order.
- R5: When several lines hold characters, the lowest line number enters the silo first. A losing line keeps its character and holds `push_ready` low until it wins.
- R6: The silo holds 64 entries. A character that wins arbitration while the silo is full is dropped. The next entry stored from that line has bit 14 (overrun) set, and later entries have it clear again.
- R7: `irq` is high while the silo is non-empty and its fill count is at least the alarm level. The alarm level is written through `alarm_we`/`alarm_wdata`. An alarm level of 0 raises `irq` for any single stored character.
- R8: `irq` is low whenever `rx_ie` is low.
- R9: A `flush_req` pulse while the silo is non-empty raises `irq` regardless of the alarm level until the silo empties. A pulse on an empty silo has no effect.
- R10: A character accepted at clock edge N is in the silo and visible on `rd_word` after edge N+1, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | NLINES | Per-line character valid |
| push_ready | output | NLINES | Per-line holding stage can accept |
| push_data | input | NLINES*8 | Per-line character, line i at bits 8i+7:8i |
| push_perr | input | NLINES | Per-line parity error with the character |
| push_ferr | input | NLINES | Per-line framing error (break) with the character |
| rd_en | input | 1 | Host read strobe, pops one entry |
| rd_word | output | 16 | Next-character word (head of silo) |
| alarm_we | input | 1 | Alarm level write strobe |
| alarm_wdata | input | 7 | New alarm level (0 to 64) |
| rx_ie | input | 1 | Receive interrupt enable |
| flush_req | input | 1 | Timer flush request pulse |
| irq | output | 1 | Receive interrupt request |

## Verification
A character driven on a push port is captured at the first edge and written into the silo at the second. The bench therefore checks `rd_word` once between those edges, where the word must still read empty, and again after the second edge, where it must show the character. `irq` follows the fill count with no added register, so it is sampled in the same half-cycle as the word. A flush pulse shows on `irq` one edge after it is applied. Popping and alarm writes take effect at the next edge, and every sample is taken on the falling clock edge after the edge that caused it.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;
  localparam int CHAR_W = 8;
  localparam int LINE_W = 4;

  typedef struct packed {
    logic              ovr;
    logic              ferr;
    logic              perr;
    logic [LINE_W-1:0] line;
    logic [CHAR_W-1:0] ch;
  } silo_ent_t;
endpackage

// File: rtl/rx_line_hold.sv
module rx_line_hold #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              in_perr,
  input  logic              in_ferr,
  output logic              in_ready,
  input  logic              grant,
  output logic              pend,
  output logic [CHAR_W-1:0] hold_data,
  output logic              hold_perr,
  output logic              hold_ferr
);
  // Free when empty, or when the held character leaves this cycle.
  assign in_ready = !pend || grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      hold_data <= '0;
      hold_perr <= 1'b0;
      hold_ferr <= 1'b0;
    end else if (in_valid && in_ready) begin
      pend      <= 1'b1;
      hold_data <= in_data;
      hold_perr <= in_perr;
      hold_ferr <= in_ferr;
    end else if (grant) begin
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_prio_arb.sv
module rx_prio_arb #(
  parameter int N     = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_silo_fifo.sv
module rx_silo_fifo #(
  parameter int W     = 15,
  parameter int DEPTH = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_wr, do_rd;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;
  assign head  = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= bump(wr_ptr);
      if (do_rd) rd_ptr <= bump(rd_ptr);
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rx_silo_irq.sv
module rx_silo_irq #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alarm_we,
  input  logic [CW-1:0] alarm_wdata,
  input  logic          rx_ie,
  input  logic          flush_req,
  input  logic [CW-1:0] count,
  output logic          irq
);
  logic [CW-1:0] alarm_lvl;
  logic          flush_pend;
  logic          nonempty;

  assign nonempty = (count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_lvl  <= '0;
      flush_pend <= 1'b0;
    end else begin
      if (alarm_we) alarm_lvl <= alarm_wdata;
      if (!nonempty)      flush_pend <= 1'b0;
      else if (flush_req) flush_pend <= 1'b1;
    end
  end

  assign irq = rx_ie && nonempty && ((count >= alarm_lvl) || flush_pend);
endmodule

// File: rtl/mux_rx_silo.sv
module mux_rx_silo
  import rx_silo_pkg::*;
#(
  parameter int NLINES = 16,
  parameter int DEPTH  = 64,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NLINES-1:0]        push_valid,
  output logic [NLINES-1:0]        push_ready,
  input  logic [NLINES*CHAR_W-1:0] push_data,
  input  logic [NLINES-1:0]        push_perr,
  input  logic [NLINES-1:0]        push_ferr,
  input  logic                     rd_en,
  output logic [15:0]              rd_word,
  input  logic                     alarm_we,
  input  logic [CNT_W-1:0]         alarm_wdata,
  input  logic                     rx_ie,
  input  logic                     flush_req,
  output logic                     irq
);
  localparam int ENT_W = $bits(silo_ent_t);

  logic [NLINES-1:0] pend, grant, ovr_pend;
  logic [CHAR_W-1:0] h_data [NLINES];
  logic [NLINES-1:0] h_perr, h_ferr;
  logic [IDX_W-1:0]  grant_idx;
  logic              grant_any, wr_acc, silo_full, silo_empty;
  logic [CNT_W-1:0]  fill_cnt;
  logic [ENT_W-1:0]  head;
  silo_ent_t         wr_ent;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    rx_line_hold #(.CHAR_W(CHAR_W)) hold_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (push_valid[g]),
      .in_data  (push_data[g*CHAR_W +: CHAR_W]),
      .in_perr  (push_perr[g]),
      .in_ferr  (push_ferr[g]),
      .in_ready (push_ready[g]),
      .grant    (grant[g]),
      .pend     (pend[g]),
      .hold_data(h_data[g]),
      .hold_perr(h_perr[g]),
      .hold_ferr(h_ferr[g])
    );
  end

  rx_prio_arb #(.N(NLINES)) arb_i (
    .req  (pend),
    .grant(grant),
    .idx  (grant_idx),
    .any  (grant_any)
  );

  always_comb begin
    wr_ent.ovr  = ovr_pend[grant_idx];
    wr_ent.ferr = h_ferr[grant_idx];
    wr_ent.perr = h_perr[grant_idx];
    wr_ent.line = LINE_W'(grant_idx);
    wr_ent.ch   = h_data[grant_idx];
  end

  assign wr_acc = grant_any && !silo_full;

  // Overrun memory: set by a drop, consumed by the next stored entry.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_pend <= '0;
    end else if (grant_any) begin
      ovr_pend[grant_idx] <= silo_full;
    end
  end

  rx_silo_fifo #(.W(ENT_W), .DEPTH(DEPTH)) fifo_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (grant_any),
    .wr_data(wr_ent),
    .rd_en  (rd_en),
    .head   (head),
    .count  (fill_cnt),
    .full   (silo_full),
    .empty  (silo_empty)
  );

  assign rd_word = silo_empty ? 16'h0000 : {1'b1, head};

  rx_silo_irq #(.CW(CNT_W)) irq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .alarm_we   (alarm_we),
    .alarm_wdata(alarm_wdata),
    .rx_ie      (rx_ie),
    .flush_req  (flush_req),
    .count      (fill_cnt),
    .irq        (irq)
  );
endmodule

// File: rtl/rx_silo_chk.sv
module rx_silo_chk #(
  parameter int NLINES = 16,
  parameter int DEPTH  = 64,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NLINES-1:0] grant,
  input logic [CW-1:0]     count,
  input logic              rd_en,
  input logic              wr_acc,
  input logic              word_vld,
  input logic              irq,
  input logic              rx_ie
);
  p_grant_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_pop_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && count != '0 && !wr_acc) |=> (count == $past(count) - 1'b1));

  p_empty_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !word_vld);

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_ie && count != '0));
endmodule

bind mux_rx_silo rx_silo_chk #(.NLINES(NLINES), .DEPTH(DEPTH)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .grant   (grant),
  .count   (fill_cnt),
  .rd_en   (rd_en),
  .wr_acc  (wr_acc),
  .word_vld(rd_word[15]),
  .irq     (irq),
  .rx_ie   (rx_ie)
);

// File: tb/mux_rx_silo_tb_top.sv
module mux_rx_silo_tb_top;
  localparam int NL = 16;
  localparam int VEC_N = 8;
  localparam logic [3:0]  V_LINE [VEC_N] = '{4'd0, 4'd15, 4'd7, 4'd9, 4'd3, 4'd12, 4'd1, 4'd10};
  localparam logic [7:0]  V_CH   [VEC_N] = '{8'h41, 8'h7E, 8'h00, 8'hFF, 8'h55, 8'hA5, 8'h80, 8'h3C};
  localparam logic        V_PE   [VEC_N] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam logic        V_FE   [VEC_N] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic [15:0] V_EXP  [VEC_N] = '{16'h8041, 16'h8F7E, 16'h9700, 16'hA9FF,
                                             16'hB355, 16'h8CA5, 16'h8180, 16'hAA3C};

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NL-1:0]   push_valid = '0;
  logic [NL-1:0]   push_ready;
  logic [NL*8-1:0] push_data = '0;
  logic [NL-1:0]   push_perr = '0;
  logic [NL-1:0]   push_ferr = '0;
  logic            rd_en = 1'b0;
  logic [15:0]     rd_word;
  logic            alarm_we = 1'b0;
  logic [6:0]      alarm_wdata = '0;
  logic            rx_ie = 1'b1;
  logic            flush_req = 1'b0;
  logic            irq;
  int              errors = 0;
  int              checks = 0;

  always #5 clk = ~clk;

  mux_rx_silo dut_i (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
    .push_data(push_data), .push_perr(push_perr), .push_ferr(push_ferr),
    .rd_en(rd_en), .rd_word(rd_word), .alarm_we(alarm_we), .alarm_wdata(alarm_wdata),
    .rx_ie(rx_ie), .flush_req(flush_req), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_one(input int line, input logic [7:0] ch, input logic pe, input logic fe);
    @(negedge clk);
    push_valid[line] = 1'b1;
    push_data[line*8 +: 8] = ch;
    push_perr[line] = pe;
    push_ferr[line] = fe;
    @(negedge clk);
    push_valid = '0;
    push_perr = '0;
    push_ferr = '0;
  endtask

  task automatic pop();
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_alarm(input logic [6:0] v);
    @(negedge clk);
    alarm_we = 1'b1;
    alarm_wdata = v;
    @(negedge clk);
    alarm_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 word", rd_word, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 ready", push_ready, 16'hFFFF);

    // R4 read of an empty silo changes nothing
    pop();
    check("R4 empty pop", rd_word, 16'h0000);

    // Table walk: R2 format, R3 flags, R10 latency
    for (int v = 0; v < VEC_N; v++) begin
      push_one(int'(V_LINE[v]), V_CH[v], V_PE[v], V_FE[v]);
      check("R10 not yet", {15'd0, rd_word[15]}, 16'd0);
      @(negedge clk);
      check("R2 R3 word", rd_word, V_EXP[v]);
      pop();
      check("R4 drained", rd_word, 16'h0000);
    end

    // R5 arbitration, lowest line first
    @(negedge clk);
    push_valid[5] = 1'b1; push_data[5*8 +: 8] = 8'h05;
    push_valid[2] = 1'b1; push_data[2*8 +: 8] = 8'h02;
    push_valid[9] = 1'b1; push_data[9*8 +: 8] = 8'h09;
    @(negedge clk);
    push_valid = '0;
    check("R5 ready line5 low", {15'd0, push_ready[5]}, 16'd0);
    check("R5 ready line9 low", {15'd0, push_ready[9]}, 16'd0);
    check("R5 ready line2 high", {15'd0, push_ready[2]}, 16'd1);
    repeat (3) @(negedge clk);
    check("R5 first", rd_word, 16'h8202);
    pop();
    check("R5 second", rd_word, 16'h8505);
    pop();
    check("R5 third", rd_word, 16'h8909);
    pop();
    check("R4 empty", rd_word, 16'h0000);

    // R6 fill to 64, drop two, overrun on next stored entry
    set_alarm(7'd64);
    for (int i = 0; i < 66; i++) begin
      @(negedge clk);
      push_valid[3] = 1'b1;
      push_data[3*8 +: 8] = 8'(i);
    end
    @(negedge clk);
    push_valid = '0;
    @(negedge clk);
    check("R7 irq at full", {15'd0, irq}, 16'd1);
    check("R6 head", rd_word, 16'h8300);
    pop();
    check("R7 irq below level", {15'd0, irq}, 16'd0);
    push_one(3, 8'hAA, 1'b0, 1'b0);
    @(negedge clk);
    for (int i = 1; i < 64; i++) begin
      check("R6 order", rd_word, 16'h8300 | 16'(i));
      pop();
    end
    check("R6 overrun flag", rd_word, 16'hC3AA);
    pop();
    check("R6 empty", rd_word, 16'h0000);
    push_one(3, 8'h11, 1'b0, 1'b0);
    @(negedge clk);
    check("R6 overrun cleared", rd_word, 16'h8311);
    pop();

    // R7 alarm level 4
    set_alarm(7'd4);
    for (int i = 0; i < 3; i++) begin
      push_one(0, 8'(i), 1'b0, 1'b0);
      @(negedge clk);
    end
    check("R7 below level", {15'd0, irq}, 16'd0);
    push_one(0, 8'h33, 1'b0, 1'b0);
    @(negedge clk);
    check("R7 at level", {15'd0, irq}, 16'd1);
    repeat (4) pop();
    check("R7 empty irq", {15'd0, irq}, 16'd0);

    // R7 alarm 0, R8 enable gate
    set_alarm(7'd0);
    push_one(6, 8'h66, 1'b0, 1'b0);
    @(negedge clk);
    check("R7 level zero", {15'd0, irq}, 16'd1);
    rx_ie = 1'b0;
    #1;
    check("R8 disabled", {15'd0, irq}, 16'd0);
    rx_ie = 1'b1;
    pop();

    // R9 flush request
    set_alarm(7'd16);
    @(negedge clk);
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    push_one(4, 8'h44, 1'b0, 1'b0);
    @(negedge clk);
    check("R9 empty flush ignored", {15'd0, irq}, 16'd0);
    push_one(4, 8'h45, 1'b0, 1'b0);
    @(negedge clk);
    check("R9 below level", {15'd0, irq}, 16'd0);
    @(negedge clk);
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    check("R9 flush irq", {15'd0, irq}, 16'd1);
    pop();
    check("R9 held", {15'd0, irq}, 16'd1);
    pop();
    check("R9 cleared", {15'd0, irq}, 16'd0);
    push_one(4, 8'h46, 1'b0, 1'b0);
    @(negedge clk);
    check("R9 no stale flush", {15'd0, irq}, 16'd0);
    pop();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule